// File: doc/BRIEF.md
# Port Status LED Controller

This block drives a small set of status LEDs (three by default) for one multi-rate Ethernet port. Each LED has two rule registers. The first lists the link conditions that hold the LED steadily lit. The second lists the per-cycle traffic and error events that make it blink. Link conditions include link speed, link-down and duplex. Traffic events are transmit or receive at each speed, collision, CRC error and idle error. Per-LED bits provide a forced-on state, a forced continuous blink, an output polarity and an enable.

Global registers hold two durations, both counted in timebase ticks: the length of a blink window and the on time of each blink phase. A control register holds a master external-control bit, a clock-enable bit and a test bit that makes the timebase tick every cycle. Software programs the block through a plain 16-bit register port. The link state and event pulses come from the surrounding MAC/PHY logic.

Top module: `led_status_ctrl`

## Requirements
- R1: Register map: control at 0x21 (stored bits 15 and 3:0, others read 0), on duration at 0x22 (reset 0x0400), blink duration at 0x23 (reset 0x0800), LED i on-rule at 0x24+2i (stored bits 15:14, 8, 6:0) and blink-rule at 0x25+2i (stored bits 11:0). Every register except the durations resets to 0. Unmapped addresses read 0. A write takes effect on the clock edge where bus_we is high, and a read returns data combinationally.
- R2: When either control bit 15 (external control) or control bit 3 (clock enable) is 0, every pin sits at its inactive level. The blink state is cleared.
- R3: With link_up high, on-rule bits 0, 1, 2 and 8 light the LED at 1000, 100, 10 and 2500 Mb/s respectively. The link_speed encoding is 0=10, 1=100, 2=1000, 3=2500.
- R4: On-rule bit 3 lights the LED while the link is down. Bits 4 and 5 light it while the link is up in full or half duplex.
- R5: On-rule bit 6 lights the LED whatever the link state is.
- R6: An ev_pulse bit that is also set in the blink-rule (bits 0-8, 10, 11; ev_pulse bit 9 is unused) starts a window of blink-duration ticks. A new match restarts the window. The window starts lit and toggles after every on-duration ticks.
- R7: Event pulses whose blink-rule bit is 0 do not affect the pin.
- R8: While a blink window is open, the blink phase overrides the steady-on result.
- R9: Blink-rule bit 9 makes the LED toggle continuously at the on-duration rate without any event.
- R10: On-rule bit 14 set makes the pin active high. When it is clear, the pin is active low.
- R11: When on-rule bit 15 is clear, the pin sits at its inactive level (the inverse of bit 14).
- R12: The timebase ticks once every PRESCALE clock cycles. Control bit 2 makes it tick every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | 0=10, 1=100, 2=1000, 3=2500 Mb/s |
| link_full_duplex | input | 1 | Full duplex when high |
| ev_pulse | input | 12 | Event pulses, same bit positions as the blink-rule |
| led_pin | output | NUM_LEDS | LED pins after polarity and enable |

## Verification
The steady rules are tested by sweeping all four speeds with three LEDs that each select a different speed set. This catches any swapped speed decode. The bench then toggles link-down and each duplex state, which separates the link-qualified conditions from the unqualified ones. Blink behaviour is measured by counting lit samples across a window. An enabled event gives an exact lit count. A disabled event gives none. An event on a steady-lit LED shows the override. Forced blink gives an even duty. The prescaled timebase must stretch the window well beyond its length in test mode.

// File: rtl/led_pkg.sv
package led_pkg;

    typedef enum logic [1:0] {
        SPD_10   = 2'd0,
        SPD_100  = 2'd1,
        SPD_1000 = 2'd2,
        SPD_2500 = 2'd3
    } speed_e;

    // register offsets
    localparam logic [7:0] ADDR_CTRL      = 8'h21;
    localparam logic [7:0] ADDR_ON_DUR    = 8'h22;
    localparam logic [7:0] ADDR_BLINK_DUR = 8'h23;
    localparam logic [7:0] ADDR_RULE_BASE = 8'h24;

    // control bits
    localparam int CTL_FAST  = 2;
    localparam int CTL_CLKEN = 3;
    localparam int CTL_EXT   = 15;

    // steady rule bits
    localparam int ON_G1000 = 0;
    localparam int ON_G100  = 1;
    localparam int ON_G10   = 2;
    localparam int ON_DOWN  = 3;
    localparam int ON_FULL  = 4;
    localparam int ON_HALF  = 5;
    localparam int ON_FORCE = 6;
    localparam int ON_G2500 = 8;
    localparam int ON_POL   = 14;
    localparam int ON_EN    = 15;

    // blink rule bits (event inputs share these positions)
    localparam int BL_FORCE = 9;
    localparam int EV_W     = 12;

    localparam logic [15:0] CTRL_MASK    = 16'h800F;
    localparam logic [15:0] ON_RULE_MASK = 16'hC17F;
    localparam logic [15:0] BL_RULE_MASK = 16'h0FFF;

    localparam logic [15:0] DUR_UNIT      = 16'd1024;
    localparam logic [15:0] BLINK_DUR_RST = DUR_UNIT << 1;
    localparam logic [15:0] ON_DUR_RST    = BLINK_DUR_RST >> 1;

endpackage

// File: rtl/led_regbank.sv
module led_regbank
    import led_pkg::*;
#(
    parameter int NUM_LEDS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic [7:0]               bus_addr,
    input  logic [15:0]              bus_wdata,
    output logic [15:0]              bus_rdata,
    output logic [15:0]              ctrl,
    output logic [15:0]              on_dur,
    output logic [15:0]              blink_dur,
    output logic [NUM_LEDS-1:0][15:0] on_rule,
    output logic [NUM_LEDS-1:0][15:0] blink_rule
);

    typedef struct packed {
        logic [15:0]               ctrl;
        logic [15:0]               on_dur;
        logic [15:0]               blink_dur;
        logic [NUM_LEDS-1:0][15:0] on_rule;
        logic [NUM_LEDS-1:0][15:0] blink_rule;
    } regs_t;

    regs_t regs_d, regs_q;

    function automatic logic [7:0] on_addr(input int idx);
        return ADDR_RULE_BASE + 8'(2 * idx);
    endfunction

    function automatic logic [7:0] bl_addr(input int idx);
        return ADDR_RULE_BASE + 8'(2 * idx + 1);
    endfunction

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            if (bus_addr == ADDR_CTRL)      regs_d.ctrl      = bus_wdata & CTRL_MASK;
            if (bus_addr == ADDR_ON_DUR)    regs_d.on_dur    = bus_wdata;
            if (bus_addr == ADDR_BLINK_DUR) regs_d.blink_dur = bus_wdata;
            for (int i = 0; i < NUM_LEDS; i++) begin
                if (bus_addr == on_addr(i)) regs_d.on_rule[i]    = bus_wdata & ON_RULE_MASK;
                if (bus_addr == bl_addr(i)) regs_d.blink_rule[i] = bus_wdata & BL_RULE_MASK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q           <= '0;
            regs_q.on_dur    <= ON_DUR_RST;
            regs_q.blink_dur <= BLINK_DUR_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL)      bus_rdata = regs_q.ctrl;
        if (bus_addr == ADDR_ON_DUR)    bus_rdata = regs_q.on_dur;
        if (bus_addr == ADDR_BLINK_DUR) bus_rdata = regs_q.blink_dur;
        for (int i = 0; i < NUM_LEDS; i++) begin
            if (bus_addr == on_addr(i)) bus_rdata = regs_q.on_rule[i];
            if (bus_addr == bl_addr(i)) bus_rdata = regs_q.blink_rule[i];
        end
    end

    assign ctrl       = regs_q.ctrl;
    assign on_dur     = regs_q.on_dur;
    assign blink_dur  = regs_q.blink_dur;
    assign on_rule    = regs_q.on_rule;
    assign blink_rule = regs_q.blink_rule;

endmodule

// File: rtl/led_timebase.sv
module led_timebase #(
    parameter int PRESCALE = 7812
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic tick
);

    localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESCALE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } tb_t;

    tb_t tb_d, tb_q;

    always_comb begin
        tb_d = tb_q;
        if (!run) begin
            tb_d.cnt  = '0;
            tb_d.tick = 1'b0;
        end else if (fast) begin
            tb_d.cnt  = '0;
            tb_d.tick = 1'b1;
        end else if (tb_q.cnt == CNT_LAST) begin
            tb_d.cnt  = '0;
            tb_d.tick = 1'b1;
        end else begin
            tb_d.cnt  = tb_q.cnt + 1'b1;
            tb_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign tick = tb_q.tick;

endmodule

// File: rtl/led_lane.sv
module led_lane
    import led_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic [15:0]     on_rule,
    input  logic [15:0]     blink_rule,
    input  logic [15:0]     on_dur,
    input  logic [15:0]     blink_dur,
    input  logic            link_up,
    input  logic [1:0]      link_speed,
    input  logic            link_full_duplex,
    input  logic [EV_W-1:0] ev_pulse,
    output logic            led_pin,
    output logic            win_active
);

    typedef struct packed {
        logic [15:0] win;
        logic [15:0] pcnt;
        logic        phase;
        logic        pin;
    } lane_t;

    lane_t ln_d, ln_q;

    localparam logic [EV_W-1:0] EV_MASK = ~(EV_W'(1) << BL_FORCE);

    logic       speed_match;
    logic       steady;
    logic       hit;
    logic       force_blink;
    logic       blinking;
    logic       lit;
    logic [16:0] pcnt_inc;
    speed_e     spd;

    assign spd = speed_e'(link_speed);

    always_comb begin
        speed_match = (spd == SPD_1000 && on_rule[ON_G1000])
                    | (spd == SPD_100  && on_rule[ON_G100])
                    | (spd == SPD_10   && on_rule[ON_G10])
                    | (spd == SPD_2500 && on_rule[ON_G2500]);
        steady = on_rule[ON_FORCE]
               | (!link_up && on_rule[ON_DOWN])
               | (link_up && (speed_match
                              | (link_full_duplex  && on_rule[ON_FULL])
                              | (!link_full_duplex && on_rule[ON_HALF])));
        hit         = |(ev_pulse & blink_rule[EV_W-1:0] & EV_MASK);
        force_blink = blink_rule[BL_FORCE];
        pcnt_inc    = {1'b0, ln_q.pcnt} + 17'd1;
    end

    always_comb begin
        ln_d = ln_q;
        if (!run) begin
            ln_d.win   = '0;
            ln_d.pcnt  = '0;
            ln_d.phase = 1'b0;
        end else if (hit) begin
            ln_d.win   = blink_dur;
            ln_d.pcnt  = '0;
            ln_d.phase = 1'b1;
        end else if (tick) begin
            if (ln_q.win != '0) ln_d.win = ln_q.win - 16'd1;
            if (pcnt_inc >= {1'b0, on_dur}) begin
                ln_d.pcnt  = '0;
                ln_d.phase = ~ln_q.phase;
            end else begin
                ln_d.pcnt = pcnt_inc[15:0];
            end
        end
        blinking = force_blink || (ln_d.win != '0);
        lit      = run && on_rule[ON_EN] && (blinking ? ln_d.phase : steady);
        ln_d.pin = lit ^ ~on_rule[ON_POL];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q     <= '0;
            ln_q.pin <= 1'b1;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign led_pin    = ln_q.pin;
    assign win_active = (ln_q.win != '0);

endmodule

// File: rtl/led_status_ctrl.sv
module led_status_ctrl
    import led_pkg::*;
#(
    parameter int NUM_LEDS = 3,
    parameter int PRESCALE = 7812
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [7:0]          bus_addr,
    input  logic [15:0]         bus_wdata,
    output logic [15:0]         bus_rdata,
    input  logic                link_up,
    input  logic [1:0]          link_speed,
    input  logic                link_full_duplex,
    input  logic [11:0]         ev_pulse,
    output logic [NUM_LEDS-1:0] led_pin
);

    logic [15:0]               ctrl_w;
    logic [15:0]               on_dur_w;
    logic [15:0]               blink_dur_w;
    logic [NUM_LEDS-1:0][15:0] on_rule_w;
    logic [NUM_LEDS-1:0][15:0] blink_rule_w;
    logic                      run_w;
    logic                      fast_w;
    logic                      tick_w;
    logic [NUM_LEDS-1:0]       pol_w;
    logic [NUM_LEDS-1:0]       en_w;
    logic [NUM_LEDS-1:0]       win_w;

    led_regbank #(.NUM_LEDS(NUM_LEDS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ctrl       (ctrl_w),
        .on_dur     (on_dur_w),
        .blink_dur  (blink_dur_w),
        .on_rule    (on_rule_w),
        .blink_rule (blink_rule_w)
    );

    assign run_w  = ctrl_w[CTL_EXT] & ctrl_w[CTL_CLKEN];
    assign fast_w = ctrl_w[CTL_FAST];

    led_timebase #(.PRESCALE(PRESCALE)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .fast  (fast_w),
        .tick  (tick_w)
    );

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_lane
        assign pol_w[i] = on_rule_w[i][ON_POL];
        assign en_w[i]  = on_rule_w[i][ON_EN];

        led_lane u_lane (
            .clk              (clk),
            .rst_n            (rst_n),
            .run              (run_w),
            .tick             (tick_w),
            .on_rule          (on_rule_w[i]),
            .blink_rule       (blink_rule_w[i]),
            .on_dur           (on_dur_w),
            .blink_dur        (blink_dur_w),
            .link_up          (link_up),
            .link_speed       (link_speed),
            .link_full_duplex (link_full_duplex),
            .ev_pulse         (ev_pulse),
            .led_pin          (led_pin[i]),
            .win_active       (win_w[i])
        );
    end

endmodule

// File: rtl/led_status_ctrl_chk.sv
module led_status_ctrl_chk #(
    parameter int NUM_LEDS = 3,
    parameter int PRESCALE = 7812
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      run,
    input logic                      fast,
    input logic                      tick,
    input logic [NUM_LEDS-1:0]       pol,
    input logic [NUM_LEDS-1:0]       en,
    input logic [NUM_LEDS-1:0]       led_pin,
    input logic [NUM_LEDS-1:0]       win,
    input logic [11:0]               ev_pulse,
    input logic [NUM_LEDS-1:0][15:0] blink_rule
);

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> led_pin == ~$past(pol)); // R2

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((led_pin ^ ~$past(pol)) & ~$past(en)) == '0); // R11

    if (PRESCALE > 1) begin : g_tick
        AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !fast) |=> !tick); // R12
    end

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_win
        AST_WINDOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(win[i]) |-> ($past(ev_pulse & blink_rule[i][11:0] & 12'hDFF) != '0)); // R6
    end

endmodule

bind led_status_ctrl led_status_ctrl_chk #(
    .NUM_LEDS (NUM_LEDS),
    .PRESCALE (PRESCALE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_w),
    .fast       (fast_w),
    .tick       (tick_w),
    .pol        (pol_w),
    .en         (en_w),
    .led_pin    (led_pin),
    .win        (win_w),
    .ev_pulse   (ev_pulse),
    .blink_rule (blink_rule_w)
);

// File: tb/led_status_ctrl_tb.sv
module led_status_ctrl_tb;

    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        link_up = 1'b0;
    logic [1:0]  link_speed = '0;
    logic        link_full_duplex = 1'b0;
    logic [11:0] ev_pulse = '0;
    logic [N-1:0] led_pin;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    led_status_ctrl #(.NUM_LEDS(N), .PRESCALE(4)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_we           (bus_we),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .link_up          (link_up),
        .link_speed       (link_speed),
        .link_full_duplex (link_full_duplex),
        .ev_pulse         (ev_pulse),
        .led_pin          (led_pin)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(input int b);
        @(negedge clk);
        ev_pulse = 12'(1) << b;
        @(posedge clk);
        @(negedge clk);
        ev_pulse = '0;
    endtask

    task automatic count_high(input int n, input int idx, output int highs);
        highs = 0;
        for (int k = 0; k < n; k++) begin
            if (led_pin[idx]) highs++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R2 reset pins inactive", 32'(led_pin), 32'h7);
        rd_check("R1 reset ctrl", 8'h21, 16'h0000);
        rd_check("R1 reset on duration", 8'h22, 16'h0400);
        rd_check("R1 reset blink duration", 8'h23, 16'h0800);
    endtask

    task automatic t_regs();
        wr(8'h24, 16'hFFFF); rd_check("R1 on-rule mask", 8'h24, 16'hC17F);
        wr(8'h29, 16'hFFFF); rd_check("R1 blink-rule mask", 8'h29, 16'h0FFF);
        wr(8'h21, 16'hFFFF); rd_check("R1 ctrl mask", 8'h21, 16'h800F);
        rd_check("R1 unmapped", 8'h30, 16'h0000);
        wr(8'h21, 16'h0000); wr(8'h24, 16'h0000); wr(8'h29, 16'h0000);
        wr(8'h22, 16'd2); wr(8'h23, 16'd8);
        rd_check("R1 duration write", 8'h23, 16'd8);
    endtask

    task automatic t_gate();
        wr(8'h24, 16'hC040);
        wr(8'h21, 16'h8008); settle();
        check("R2 running pin0", 32'(led_pin[0]), 1);
        wr(8'h21, 16'h0008); settle();
        check("R2 ext ctrl clear", 32'(led_pin[0]), 0);
        wr(8'h21, 16'h8000); settle();
        check("R2 clock enable clear", 32'(led_pin[0]), 0);
        wr(8'h21, 16'h8008);
    endtask

    task automatic t_speed();
        wr(8'h24, 16'hC001); wr(8'h26, 16'hC102); wr(8'h28, 16'hC004);
        link_up = 1'b1;
        for (int s = 0; s < 4; s++) begin
            link_speed = 2'(s); settle();
            check("R3 speed pattern", 32'(led_pin),
                  32'({s == 0, (s == 1 || s == 3), s == 2}));
        end
        link_up = 1'b0; settle();
        check("R3 link down clears speed rules", 32'(led_pin), 0);
    endtask

    task automatic t_duplex();
        wr(8'h24, 16'hC008); wr(8'h26, 16'hC010); wr(8'h28, 16'hC020);
        link_up = 1'b0; link_full_duplex = 1'b1; settle();
        check("R4 link down", 32'(led_pin), 32'b001);
        link_up = 1'b1; settle();
        check("R4 full duplex", 32'(led_pin), 32'b010);
        link_full_duplex = 1'b0; settle();
        check("R4 half duplex", 32'(led_pin), 32'b100);
    endtask

    task automatic t_force_pol_en();
        link_up = 1'b0;
        wr(8'h24, 16'hC040); wr(8'h26, 16'h0000); wr(8'h28, 16'h0000); settle();
        check("R5 force on", 32'(led_pin[0]), 1);
        wr(8'h24, 16'h8040); settle();
        check("R10 active low lit", 32'(led_pin[0]), 0);
        wr(8'h24, 16'h8000); settle();
        check("R10 active low dark", 32'(led_pin[0]), 1);
        wr(8'h24, 16'h4040); wr(8'h26, 16'h0040); settle();
        check("R11 disabled high pol", 32'(led_pin[0]), 0);
        check("R11 disabled low pol", 32'(led_pin[1]), 1);
    endtask

    task automatic t_blink();
        int h;
        wr(8'h21, 16'h800C);
        wr(8'h26, 16'h0000);
        wr(8'h24, 16'hC000); wr(8'h25, 16'h0001); settle();
        pulse(0); count_high(16, 0, h);
        check("R6 blink window lit count", h, 4);
        pulse(1); count_high(16, 0, h);
        check("R7 unselected event ignored", h, 0);
        wr(8'h24, 16'hC040); settle();
        pulse(0); count_high(16, 0, h);
        check("R8 blink overrides steady", h, 12);
        wr(8'h24, 16'hC000); wr(8'h25, 16'h0200); settle();
        count_high(16, 0, h);
        check("R9 force blink duty", h, 8);
    endtask

    task automatic t_prescale();
        int h1, h2;
        wr(8'h21, 16'h8008);
        wr(8'h25, 16'h0001); repeat (8) @(negedge clk);
        pulse(0);
        count_high(40, 0, h1);
        count_high(24, 0, h2);
        check("R12 prescaled window lit low bound", 32'(h1 >= 12), 1);
        check("R12 prescaled window lit high bound", 32'(h1 <= 16), 1);
        check("R12 prescaled window closed", h2, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_gate();
        t_speed();
        t_duplex();
        t_force_pol_en();
        t_blink();
        t_prescale();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule